// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

This block gathers 112 interrupt inputs and drives one interrupt line. The sources are grouped into two masters, each with seven blocks of eight sources. Every block has three registers at fixed addresses in its master's window, so software needs no select register to reach them:
- a pending register, which is also the clear register;
- a mask register;
- a raw-level register.

Each source latches an event into its pending bit. Detection is either on the rising edge or on the level, and a parameter picks one of the two. A pending bit stays set until software writes a one to that bit. Per block, the pending bits are combined with the mask bits into summary bits, one summary register per master. Bit 0 of master 0's summary reports any activity under master 1. A handler therefore reads master 0's summary first and reads master 1's summary only when bit 0 is set. The interrupt output is the OR of master 0's summary.

Register access goes through an 8-bit port:
- A write takes one clock, qualified by a write enable.
- Read data is a combinational function of the address.

Top module: `irq_cascade`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, and `irq_o` is low.
- R2: Master 0's window starts at 0x130 and master 1's at 0x1B0. For local block k (0..6) the pending/clear register is at window+1+k, the mask register at window+8+k and the raw-level register at window+15+k. The summary register is at window+0. Source number (m*7+k)*8+b maps to bit b of block k in master m. Any other address reads 0.
- R3: In a master's summary register, bit k+1 is 1 exactly when local block k has at least one bit that is both pending and unmasked. Bit 0 of master 0's summary is 1 when any summary bit 7..1 of master 1 is 1. Bit 0 of master 1's summary reads 0.
- R4: With edge detection (LEVEL_MODE=0), a pending bit is set on the clock edge where its source is high and was low at the previous edge. Once set, it stays set until it is cleared.
- R5: Writing a byte to a pending/clear address clears each pending bit whose data bit is 1. If a new event for a bit arrives in the same clock, the bit stays set.
- R6: Data bits that are 0 in a write to a pending/clear address leave the corresponding pending bits unchanged.
- R7: A write to a mask address loads that block's mask, where 1 masks a source. A masked source still sets its pending bit.
- R8: A pending bit that is masked sets no summary bit and does not raise `irq_o`.
- R9: A raw-level register returns the current levels of its eight sources, whatever the pending and mask state.
- R10: `irq_o` is the OR of master 0's summary bits.
- R11: With level detection (LEVEL_MODE=1), a pending bit is set on every clock edge where its source is high. A clear written while the source stays high therefore leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 112 | Interrupt source levels, indexed by source number |
| addr_i | input | 10 | Register address |
| wr_en_i | input | 1 | Write strobe for one clock |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The bench builds two instances that share one stimulus stream, one with LEVEL_MODE=0 and one with LEVEL_MODE=1. The behaviour of the two instances differs only when a clear arrives while a source is still high, so comparing them brings the re-latch of R11 within reach next to the edge behaviour of R4. The default window bases and seven blocks per master are kept. This puts the master 1 to master 0 cascade bit, the unmapped gaps after each window, and the highest source number (111) under test.

// File: rtl/irq_cascade.sv
module irq_cascade #(
  parameter int          BLK_PER_M   = 7,
  parameter int          SRC_PER_BLK = 8,
  parameter int          ADDR_W      = 10,
  parameter int          BASE_M0     = 'h130,
  parameter int          BASE_M1     = 'h1B0,
  parameter bit          LEVEL_MODE  = 1'b0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [2*BLK_PER_M*SRC_PER_BLK-1:0]     src_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic                                   wr_en_i,
  input  logic [SRC_PER_BLK-1:0]                 wdata_i,
  output logic [SRC_PER_BLK-1:0]                 rdata_o,
  output logic                                   irq_o
);
  localparam int NBLK = 2 * BLK_PER_M;
  localparam int NSRC = NBLK * SRC_PER_BLK;
  localparam int W    = SRC_PER_BLK;

  function automatic int base_of(int g);
    return (g / BLK_PER_M == 0) ? BASE_M0 : BASE_M1;
  endfunction

  logic [NSRC-1:0] pend, mask, src_q, evt;
  logic [NBLK-1:0] blk_any;
  logic [W-1:0]    sum0, sum1;

  assign evt = LEVEL_MODE ? src_i : (src_i & ~src_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam int K = g % BLK_PER_M;
    localparam int B = base_of(g);
    logic          hit_clr, hit_msk;
    logic [W-1:0]  clr;

    assign hit_clr = wr_en_i && (addr_i == ADDR_W'(B + 1 + K));
    assign hit_msk = wr_en_i && (addr_i == ADDR_W'(B + BLK_PER_M + 1 + K));
    assign clr     = hit_clr ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pend[g*W +: W] <= '0;
        mask[g*W +: W] <= '1;
      end else begin
        pend[g*W +: W] <= (pend[g*W +: W] & ~clr) | evt[g*W +: W];
        if (hit_msk) mask[g*W +: W] <= wdata_i;
      end

    assign blk_any[g] = |(pend[g*W +: W] & ~mask[g*W +: W]);
  end

  always_comb begin
    sum0 = '0;
    sum1 = '0;
    sum1[BLK_PER_M:1] = blk_any[NBLK-1:BLK_PER_M];
    sum0[BLK_PER_M:1] = blk_any[BLK_PER_M-1:0];
    sum0[0]           = |sum1;
  end

  assign irq_o = |sum0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(BASE_M0)) rdata_o = sum0;
    if (addr_i == ADDR_W'(BASE_M1)) rdata_o = sum1;
    for (int g = 0; g < NBLK; g++) begin
      if (addr_i == ADDR_W'(base_of(g) + 1 + g % BLK_PER_M))
        rdata_o = pend[g*W +: W];
      if (addr_i == ADDR_W'(base_of(g) + BLK_PER_M + 1 + g % BLK_PER_M))
        rdata_o = mask[g*W +: W];
      if (addr_i == ADDR_W'(base_of(g) + 2*BLK_PER_M + 1 + g % BLK_PER_M))
        rdata_o = src_i[g*W +: W];
    end
  end

  // R4: with no write, no pending bit may fall
  a_r4_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ((pend & $past(pend)) == $past(pend)));

  // R6: an all-zero write clears nothing
  a_r6_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wdata_i == '0) |=> ((pend & $past(pend)) == $past(pend)));

  // R5: clearing source 0 while it stays low leaves it clear
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(BASE_M0 + 1) && wdata_i[0] && !src_i[0])
    |=> !pend[0]);

  // R7: mask write lands in the addressed block
  a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(BASE_M0 + BLK_PER_M + 1))
    |=> (mask[W-1:0] == $past(wdata_i)));

  // R8: fully masked state never raises the output
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq_o);
endmodule

// File: tb/irq_cascade_bench.sv
`timescale 1ns/1ps
module irq_cascade_bench;
  localparam int NB = 14;
  localparam int NS = 112;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [9:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rd_e, rd_l;
  logic          irq_e, irq_l;

  int ntot = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  irq_cascade #(.LEVEL_MODE(1'b0)) u_irq_cascade (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rd_e), .irq_o(irq_e));

  irq_cascade #(.LEVEL_MODE(1'b1)) u_irq_cascade_lvl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rd_l), .irq_o(irq_l));

  // reference state, built from the requirements
  logic [NS-1:0] m_pe, m_pl, m_mask, m_prev;

  function automatic int wbase(int g);
    return (g / 7 == 0) ? 'h130 : 'h1B0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pe = '0; m_pl = '0; m_mask = '1; m_prev = '0;
    end else begin
      logic [NS-1:0] clr;
      clr = '0;
      for (int g = 0; g < NB; g++) begin
        if (wr_en && addr == 10'(wbase(g) + 1 + g % 7)) clr[g*8 +: 8] = wdata;
        if (wr_en && addr == 10'(wbase(g) + 8 + g % 7)) m_mask[g*8 +: 8] = wdata;
      end
      m_pe = (m_pe & ~clr) | (src & ~m_prev);
      m_pl = (m_pl & ~clr) | src;
      m_prev = src;
    end
  end

  function automatic logic [7:0] summ(bit lvl, int m);
    logic [NS-1:0] p;
    logic [7:0] s;
    p = lvl ? m_pl : m_pe;
    s = '0;
    for (int k = 0; k < 7; k++)
      s[k+1] = |(p[(m*7+k)*8 +: 8] & ~m_mask[(m*7+k)*8 +: 8]);
    if (m == 0) s[0] = |summ(lvl, 1);
    return s;
  endfunction

  function automatic logic [7:0] exp_read(bit lvl, int a);
    logic [NS-1:0] p;
    logic [7:0] r;
    p = lvl ? m_pl : m_pe;
    r = '0;
    if (a == 'h130) r = summ(lvl, 0);
    if (a == 'h1B0) r = summ(lvl, 1);
    for (int g = 0; g < NB; g++) begin
      if (a == wbase(g) + 1 + g % 7)  r = p[g*8 +: 8];
      if (a == wbase(g) + 8 + g % 7)  r = m_mask[g*8 +: 8];
      if (a == wbase(g) + 15 + g % 7) r = src[g*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, int a);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, int a);
    @(negedge clk);
    addr = 10'(a);
    #1;
    chk({tag, " edge"}, rd_e, exp_read(0, a), a);
    chk({tag, " level"}, rd_l, exp_read(1, a), a);
  endtask

  task automatic irq_chk(string tag);
    @(negedge clk);
    #1;
    chk({tag, " irq edge"}, {7'd0, irq_e}, {7'd0, |summ(0, 0)}, 0);
    chk({tag, " irq level"}, {7'd0, irq_l}, {7'd0, |summ(1, 0)}, 0);
  endtask

  task automatic check_all(string tag);
    for (int m = 0; m < 2; m++) begin
      int b;
      b = (m == 0) ? 'h130 : 'h1B0;
      for (int o = 0; o < 22; o++) begin
        string t;
        t = (tag != "") ? tag : (o == 0) ? "R3" : (o < 8) ? "R4" : (o < 15) ? "R7" : "R9";
        rd_chk(t, b + o);
      end
      rd_chk((tag != "") ? tag : "R2", b + 22);
    end
    rd_chk((tag != "") ? tag : "R2", 'h000);
    rd_chk((tag != "") ? tag : "R2", 'h3FF);
    irq_chk((tag != "") ? tag : "R10");
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 10'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      ntot++; nbad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    check_all("R1");

    for (int g = 0; g < NB; g++) wr(wbase(g) + 8 + g % 7, 8'h00);
    check_all("R7");

    // source 0 rises
    @(negedge clk); src[0] = 1'b1;
    idle(2);
    rd_chk("R4", 'h131);
    rd_chk("R3", 'h130);
    irq_chk("R10");
    // zero write leaves it
    wr('h131, 8'h00);
    rd_chk("R6", 'h131);
    // clear while high: edge clears, level relatches
    wr('h131, 8'h01);
    rd_chk("R11", 'h131);
    @(negedge clk); src[0] = 1'b0;
    wr('h131, 8'h01);
    rd_chk("R5", 'h131);
    irq_chk("R5");

    // highest source in master 1, cascade into master 0
    @(negedge clk); src[111] = 1'b1;
    idle(2);
    rd_chk("R3", 'h1B0);
    rd_chk("R3", 'h130);
    rd_chk("R9", 'h1C5);
    wr('h1BE, 8'hFF);
    rd_chk("R7", 'h1B7);
    rd_chk("R8", 'h1B0);
    rd_chk("R8", 'h130);
    irq_chk("R8");
    @(negedge clk); src[111] = 1'b0;
    wr('h1B7, 8'hFF);
    wr('h1BE, 8'h00);

    // new event in the cycle of its clear
    @(negedge clk);
    src[8] = 1'b1; addr = 10'h132; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd_chk("R5", 'h132);
    check_all("");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int g, sel;
      @(negedge clk);
      for (int j = 0; j < 3; j++) src[$urandom_range(NS-1)] ^= 1'b1;
      g = $urandom_range(NB-1);
      sel = $urandom_range(9);
      if (sel < 5)      wr(wbase(g) + 1 + g % 7, 8'($urandom));
      else if (sel < 7) wr(wbase(g) + 8 + g % 7, 8'($urandom) & 8'($urandom));
      else if (sel < 8) wr(wbase(g) + 15 + g % 7, 8'($urandom));
      if (it % 40 == 39) check_all("");
    end
    check_all("");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule